// File: doc/BRIEF.md
# DRAM Cycle Decoder with Latched Parallel Test Mode

This block is the control side of a dynamic memory array. It samples the row strobe, column strobe and write enable (all active low) on the system clock, decides what kind of memory cycle each row-strobe period is, and steers the array accordingly. A column strobe inside an open row gives a read or an early write. A row strobe with no column strobe is a refresh of the row on the address pins. A column strobe already low when the row strobe falls gives a refresh from an internal row counter, and the address pins are ignored. When write enable is also low at that edge, the block enters a latched parallel test mode.

In test mode every group of eight cells that differ only in row bit 10, column bit 10 and column bit 0 is handled as one unit. A write fills all eight cells with the data bit. A read returns 1 when the eight cells agree and 0 when any of them differs, one clock later than a normal read. This models the longer test-mode access time. Either kind of refresh cycle returns the block to normal operation.

The cell array is a small stand-in. It keeps only the low `ROW_KEEP` row bits and the low `COL_KEEP+1` column bits, plus the three grouping bits. Addresses that differ only in other bits alias to the same cell.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After synchronous reset every output is 0: `cyc_type` = 0 (none), `cyc_valid`, `ref_row`, `ref_inc`, `test_mode`, `dout`, `rd_valid`.
- R2: If `cas_n` is low at the clock where `ras_n` is first sampled low and `we_n` is high, the cycle is a counter refresh. `cyc_type` = 4 and `cyc_valid` pulses for one cycle right after that edge. The address pins are ignored. Column strobe activity during that row period causes no read or write.
- R3: At the edge where `ras_n` is sampled high again after any counter refresh (code 4 or 5), `ref_row` advances by one and `ref_inc` pulses for one cycle. `ref_row` wraps from `REF_ROWS`-1 (default 1023) to 0.
- R4: A row period opened with `cas_n` high and closed without a column strobe fall is a RAS-only refresh. `cyc_type` = 3 and `cyc_valid` pulses right after the closing edge. `ref_row` does not change.
- R5: A column strobe fall inside an open row with `we_n` high is a read. `cyc_type` = 1, and outside test mode `dout` shows the addressed cell with `rd_valid` high right after that edge.
- R6: A column strobe fall inside an open row with `we_n` low is an early write of `din`, with `cyc_type` = 2. Several column strobes within one row period each make a separate access to the latched row (page mode).
- R7: If `cas_n` and `we_n` are both low when `ras_n` falls, `test_mode` becomes 1 and `cyc_type` = 5 right after that edge.
- R8: `test_mode` stays set through reads, writes and repeated entry cycles. It is cleared only by a RAS-only refresh or a code-4 counter refresh.
- R9: A write in test mode stores `din` into all eight cells that differ only in row bit 10, column bit 10 and column bit 0.
- R10: A read in test mode returns 1 when those eight cells are equal and 0 otherwise. `rd_valid` and `dout` arrive one clock later than for a normal read.
- R11: A hidden refresh is handled as a counter refresh. This is the case where `ras_n` goes high and falls again while `cas_n` stays low after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row / column address |
| din | input | 1 | Write data bit |
| cyc_type | output | 3 | Last classified cycle: 0 none, 1 read, 2 write, 3 RAS-only refresh, 4 counter refresh, 5 test entry |
| cyc_valid | output | 1 | One-cycle pulse when `cyc_type` is updated |
| ref_row | output | ADDR_W | Internal refresh row counter |
| ref_inc | output | 1 | One-cycle pulse when the counter advances |
| test_mode | output | 1 | Latched test-mode flag |
| dout | output | 1 | Read data or compressed test result |
| rd_valid | output | 1 | One-cycle pulse when `dout` is updated |

## Verification
Page-mode writes and reads use addresses that differ only in a grouping bit. A misplaced bit select therefore shows up as wrong data. A refresh opened with the column strobe already low is compared against a RAS-only refresh, which tells counter-driven cycles from address-driven ones. It also confirms that column strobe toggles inside the counter cycle leave stored data untouched. Test-mode writes and compressed reads are run once over an equal group and once over a group in which one cell was made different by a normal write. Test mode is then left by each refresh kind, and the run is repeated until the counter wraps.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;

    typedef enum logic [2:0] {
        CYC_NONE  = 3'd0,
        CYC_READ  = 3'd1,
        CYC_WRITE = 3'd2,
        CYC_ROR   = 3'd3,
        CYC_CBR   = 3'd4,
        CYC_TEST  = 3'd5
    } cyc_e;

    // one array access request, valid for the edge it is raised in
    typedef struct packed {
        logic rd;
        logic wr;
        logic tm;
        logic din;
    } acc_t;

    localparam int GROUP_SIZE = 8;

    function automatic int unsigned wrap_inc(int unsigned v, int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/dcd_cycle_fsm.sv
`timescale 1ns/1ps
module dcd_cycle_fsm
    import dcd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output cyc_e              cyc_type,
    output logic              cyc_valid,
    output logic              test_mode,
    output logic              cbr_done,
    output acc_t              acc,
    output logic [ADDR_W-1:0] acc_row,
    output logic [ADDR_W-1:0] acc_col
);

    logic ras_d, cas_d;
    logic active, cbr, cas_seen;
    logic [ADDR_W-1:0] row_q;
    logic ras_fall, ras_rise, cas_fall;

    assign ras_fall = ras_d & ~ras_n;
    assign ras_rise = ~ras_d & ras_n & active;
    assign cas_fall = cas_d & ~cas_n;
    assign cbr_done = ras_rise & cbr;

    always_comb begin
        acc.rd  = active & ~cbr & ~ras_n & cas_fall & we_n;
        acc.wr  = active & ~cbr & ~ras_n & cas_fall & ~we_n;
        acc.tm  = test_mode;
        acc.din = din;
    end

    assign acc_row = row_q;
    assign acc_col = addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_d     <= 1'b1;
            cas_d     <= 1'b1;
            active    <= 1'b0;
            cbr       <= 1'b0;
            cas_seen  <= 1'b0;
            row_q     <= '0;
            test_mode <= 1'b0;
            cyc_type  <= CYC_NONE;
            cyc_valid <= 1'b0;
        end else begin
            ras_d     <= ras_n;
            cas_d     <= cas_n;
            cyc_valid <= 1'b0;
            if (ras_fall) begin
                active    <= 1'b1;
                cas_seen  <= 1'b0;
                cbr       <= ~cas_n;
                row_q     <= addr;
                cyc_valid <= ~cas_n;
                if (~cas_n) begin
                    if (~we_n) begin
                        test_mode <= 1'b1;
                        cyc_type  <= CYC_TEST;
                    end else begin
                        test_mode <= 1'b0;
                        cyc_type  <= CYC_CBR;
                    end
                end
            end else if (ras_rise) begin
                active <= 1'b0;
                cbr    <= 1'b0;
                if (~cbr && ~cas_seen) begin
                    cyc_valid <= 1'b1;
                    cyc_type  <= CYC_ROR;
                    test_mode <= 1'b0;
                end
            end else if (acc.rd || acc.wr) begin
                cas_seen  <= 1'b1;
                cyc_valid <= 1'b1;
                cyc_type  <= acc.wr ? CYC_WRITE : CYC_READ;
            end
        end
    end

    // R7: entry edge latches test mode and reports code 5
    p_tm_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (ras_fall && !cas_n && !we_n) |=> (test_mode && cyc_valid && cyc_type == CYC_TEST));

    // R8: test mode only drops together with a refresh report
    p_tm_exit_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(test_mode) |-> (cyc_valid && (cyc_type == CYC_ROR || cyc_type == CYC_CBR)));

    // R8: a reported refresh of either kind leaves test mode off
    p_tm_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && (cyc_type == CYC_ROR || cyc_type == CYC_CBR)) |-> !test_mode);

    // R2: a column strobe inside a counter refresh is not reported as an access
    p_cbr_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (active && cbr && !ras_n && cas_fall) |=> !cyc_valid);

endmodule

// File: rtl/dcd_refresh_ctr.sv
`timescale 1ns/1ps
module dcd_refresh_ctr
    import dcd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int ROWS  = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] row,
    output logic             inc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
            inc <= 1'b0;
        end else begin
            inc <= step;
            if (step) row <= CNT_W'(wrap_inc(int'(row), ROWS));
        end
    end

    // R3: counter never leaves its row range
    p_row_range_r3: assert property (@(posedge clk) disable iff (rst)
        int'(row) < ROWS);

    // R3: each strobe is one step with wrap
    p_row_step_r3: assert property (@(posedge clk) disable iff (rst)
        inc |-> (int'(row) == int'(wrap_inc(int'($past(row)), ROWS))));

    // R3: without a strobe the counter holds
    p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !inc |-> $stable(row));

endmodule

// File: rtl/dcd_cell_store.sv
`timescale 1ns/1ps
module dcd_cell_store
    import dcd_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int ROW_KEEP = 2,
    parameter int COL_KEEP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    output logic              dout,
    output logic              rd_valid
);

    localparam int IDX_W = ROW_KEEP + COL_KEEP;
    localparam int DEPTH = 1 << IDX_W;

    logic [GROUP_SIZE-1:0] mem [DEPTH];
    logic [IDX_W-1:0]      idx;
    logic [2:0]            bsel;
    logic [GROUP_SIZE-1:0] word;
    logic                  agree;
    logic                  s1_vld, s1_val;
    logic                  unused_bits;

    assign idx   = {row[ROW_KEEP-1:0], col[COL_KEEP:1]};
    assign bsel  = {row[ADDR_W-1], col[ADDR_W-1], col[0]};
    assign word  = mem[idx];
    assign agree = (&word) | ~(|word);
    assign unused_bits = ^{row[ADDR_W-2:ROW_KEEP], col[ADDR_W-2:COL_KEEP+1]};

    always_ff @(posedge clk) begin
        if (acc.wr) begin
            if (acc.tm) mem[idx] <= {GROUP_SIZE{acc.din}};
            else        mem[idx][bsel] <= acc.din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout     <= 1'b0;
            rd_valid <= 1'b0;
            s1_vld   <= 1'b0;
            s1_val   <= 1'b0;
        end else begin
            s1_vld <= acc.rd & acc.tm;
            s1_val <= agree;
            if (acc.rd && !acc.tm) begin
                dout     <= word[bsel];
                rd_valid <= 1'b1;
            end else if (s1_vld) begin
                dout     <= s1_val;
                rd_valid <= 1'b1;
            end else begin
                rd_valid <= 1'b0;
            end
        end
    end

    // R10: a compressed read answers one clock later than a normal one
    p_test_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && acc.tm) |=> (!rd_valid ##1 rd_valid));

    // R5: a normal read answers at the next edge
    p_read_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (acc.rd && !acc.tm) |=> rd_valid);

    // R9: after a test write the whole group agrees
    p_group_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (acc.wr && acc.tm) |=> agree);

endmodule

// File: rtl/dram_cycle_decoder.sv
`timescale 1ns/1ps
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int REF_ROWS = 1024,
    parameter int ROW_KEEP = 2,
    parameter int COL_KEEP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [2:0]        cyc_type,
    output logic              cyc_valid,
    output logic [ADDR_W-1:0] ref_row,
    output logic              ref_inc,
    output logic              test_mode,
    output logic              dout,
    output logic              rd_valid
);

    localparam int CNT_W = ADDR_W;

    cyc_e              cyc_e_q;
    acc_t              acc;
    logic              cbr_done;
    logic [ADDR_W-1:0] acc_row, acc_col;

    dcd_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .din       (din),
        .cyc_type  (cyc_e_q),
        .cyc_valid (cyc_valid),
        .test_mode (test_mode),
        .cbr_done  (cbr_done),
        .acc       (acc),
        .acc_row   (acc_row),
        .acc_col   (acc_col)
    );

    dcd_refresh_ctr #(.CNT_W(CNT_W), .ROWS(REF_ROWS)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .step (cbr_done),
        .row  (ref_row),
        .inc  (ref_inc)
    );

    dcd_cell_store #(.ADDR_W(ADDR_W), .ROW_KEEP(ROW_KEEP), .COL_KEEP(COL_KEEP)) u_store (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .row      (acc_row),
        .col      (acc_col),
        .dout     (dout),
        .rd_valid (rd_valid)
    );

    assign cyc_type = cyc_e_q;

endmodule

// File: tb/test_dram_cycle_decoder.sv
`timescale 1ns/1ps
module test_dram_cycle_decoder;

    localparam int AW   = 11;
    localparam int ROWS = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [2:0]    cyc_type;
    logic          cyc_valid, ref_inc, test_mode, dout, rd_valid;
    logic [AW-1:0] ref_row;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dram_cycle_decoder i_dram_cycle_decoder (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .cyc_type(cyc_type), .cyc_valid(cyc_valid),
        .ref_row(ref_row), .ref_inc(ref_inc), .test_mode(test_mode),
        .dout(dout), .rd_valid(rd_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at falling edge, return 1 ns after the next rising edge
    task automatic step(input logic r, input logic c, input logic w,
                        input logic [AW-1:0] a, input logic d);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1, 1, 1, '0, 0);
    endtask

    task automatic t_reset();
        chk("R1 cyc_type", cyc_type, 0);
        chk("R1 cyc_valid", cyc_valid, 0);
        chk("R1 ref_row", ref_row, 0);
        chk("R1 ref_inc", ref_inc, 0);
        chk("R1 test_mode", test_mode, 0);
        chk("R1 dout/rd_valid", {dout, rd_valid}, 0);
    endtask

    task automatic t_page_write_read();
        step(0, 1, 1, 11'h401, 0);
        chk("R4 no report on open", cyc_valid, 0);
        step(0, 0, 0, 11'h005, 1);
        chk("R6 write reported", {cyc_valid, cyc_type}, {1'b1, 3'd2});
        step(0, 1, 1, 11'h005, 0);
        step(0, 0, 0, 11'h004, 0);
        chk("R6 page write 2", {cyc_valid, cyc_type}, {1'b1, 3'd2});
        step(0, 1, 1, 11'h004, 0);
        step(0, 0, 0, 11'h405, 0);
        chk("R6 page write 3", {cyc_valid, cyc_type}, {1'b1, 3'd2});
        step(0, 1, 1, 11'h405, 0);
        step(1, 1, 1, 11'h000, 0);
        chk("R4 close after access not refresh", cyc_valid, 0);
        idle();
        step(0, 1, 1, 11'h401, 0);
        step(0, 0, 1, 11'h005, 0);
        chk("R5 read reported", {cyc_valid, cyc_type}, {1'b1, 3'd1});
        chk("R5 read data col5", {rd_valid, dout}, 2'b11);
        step(0, 1, 1, 11'h005, 0);
        step(0, 0, 1, 11'h004, 0);
        chk("R6 page read col4", {rd_valid, dout}, 2'b10);
        step(0, 1, 1, 11'h004, 0);
        step(0, 0, 1, 11'h405, 0);
        chk("R6 page read col bit10", {rd_valid, dout}, 2'b10);
        step(0, 1, 1, 11'h405, 0);
        step(1, 1, 1, 11'h000, 0);
        idle();
    endtask

    task automatic t_ras_only();
        logic [AW-1:0] r0 = ref_row;
        step(0, 1, 1, 11'h123, 0);
        step(0, 1, 1, 11'h123, 0);
        step(1, 1, 1, 11'h123, 0);
        chk("R4 ras-only reported", {cyc_valid, cyc_type}, {1'b1, 3'd3});
        step(1, 1, 1, 11'h000, 0);
        chk("R4 counter untouched", {ref_inc, ref_row}, {1'b0, r0});
    endtask

    task automatic cbr(input logic w);
        step(1, 0, w, 11'h7ff, 0);
        step(0, 0, w, 11'h7ff, 0);
        step(1, 0, 1, 11'h7ff, 0);
        step(1, 1, 1, 11'h000, 0);
    endtask

    task automatic t_cbr();
        logic [AW-1:0] r0 = ref_row;
        step(1, 0, 1, 11'h005, 0);
        chk("R2 strobe with row closed ignored", cyc_valid, 0);
        step(0, 0, 1, 11'h401, 0);
        chk("R2 counter refresh reported", {cyc_valid, cyc_type}, {1'b1, 3'd4});
        step(0, 1, 1, 11'h401, 0);
        step(0, 0, 0, 11'h005, 0);
        chk("R2 strobe in refresh not an access", cyc_valid, 0);
        step(1, 0, 1, 11'h000, 0);
        chk("R3 step on close", {ref_inc, ref_row}, {1'b1, AW'(r0 + 1)});
        step(1, 1, 1, 11'h000, 0);
        chk("R3 strobe one cycle", ref_inc, 0);
        step(0, 1, 1, 11'h401, 0);
        step(0, 0, 1, 11'h005, 0);
        chk("R2 cell kept after ignored write", {rd_valid, dout}, 2'b11);
        step(0, 1, 1, 11'h005, 0);
        step(1, 1, 1, 11'h000, 0);
        idle();
    endtask

    task automatic t_hidden();
        logic [AW-1:0] r0 = ref_row;
        step(0, 1, 1, 11'h401, 0);
        step(0, 0, 1, 11'h005, 0);
        chk("R11 read before hidden refresh", {rd_valid, dout}, 2'b11);
        step(1, 0, 1, 11'h005, 0);
        step(0, 0, 1, 11'h005, 0);
        chk("R11 hidden refresh is code 4", {cyc_valid, cyc_type}, {1'b1, 3'd4});
        step(1, 0, 1, 11'h005, 0);
        chk("R11 hidden refresh steps counter", ref_row, AW'(r0 + 1));
        idle();
    endtask

    task automatic t_wrap();
        int guard = 0;
        while (ref_row != AW'(ROWS - 1) && guard < 2000) begin
            cbr(1);
            guard++;
        end
        chk("R3 reached last row", ref_row, ROWS - 1);
        step(1, 0, 1, 11'h000, 0);
        step(0, 0, 1, 11'h000, 0);
        step(1, 0, 1, 11'h000, 0);
        chk("R3 wrap to zero", {ref_inc, ref_row}, {1'b1, 11'h000});
        idle();
    endtask

    task automatic test_read(input logic [AW-1:0] r, input logic [AW-1:0] c,
                             input int exp, input string tag);
        step(0, 1, 1, r, 0);
        step(0, 0, 1, c, 0);
        chk({"R10 no early answer ", tag}, rd_valid, 0);
        step(0, 0, 1, c, 0);
        chk({"R10 compressed result ", tag}, {rd_valid, dout}, {1'b1, 1'(exp)});
        step(0, 1, 1, c, 0);
        step(1, 1, 1, 11'h000, 0);
    endtask

    task automatic t_test_mode();
        step(1, 0, 0, 11'h000, 0);
        step(0, 0, 0, 11'h000, 0);
        chk("R7 entry reported", {cyc_valid, cyc_type, test_mode}, {1'b1, 3'd5, 1'b1});
        step(1, 0, 1, 11'h000, 0);
        step(1, 1, 1, 11'h000, 0);
        step(0, 1, 1, 11'h002, 0);
        step(0, 0, 0, 11'h006, 1);
        step(0, 1, 1, 11'h006, 0);
        step(1, 1, 1, 11'h000, 0);
        chk("R8 held after write", test_mode, 1);
        test_read(11'h002, 11'h006, 1, "equal");
        chk("R8 held after read", test_mode, 1);
        step(0, 1, 1, 11'h002, 0);
        step(1, 1, 1, 11'h002, 0);
        chk("R8 ras-only clears", {cyc_type, test_mode}, {3'd3, 1'b0});
        step(0, 1, 1, 11'h402, 0);
        step(0, 0, 1, 11'h407, 0);
        chk("R9 group member filled", {rd_valid, dout}, 2'b11);
        step(0, 1, 1, 11'h407, 0);
        step(0, 0, 0, 11'h407, 0);
        step(0, 1, 1, 11'h407, 0);
        step(1, 1, 1, 11'h000, 0);
        cbr(0);
        cbr(0);
        chk("R8 repeat entry keeps mode", test_mode, 1);
        test_read(11'h002, 11'h006, 0, "differs");
        step(1, 0, 1, 11'h000, 0);
        step(0, 0, 1, 11'h000, 0);
        chk("R8 counter refresh clears", {cyc_type, test_mode}, {3'd4, 1'b0});
        step(1, 0, 1, 11'h000, 0);
        idle();
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        t_reset();
        t_page_write_read();
        t_ras_only();
        t_cbr();
        t_hidden();
        t_test_mode();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule